// File: doc/BRIEF.md
# Asynchronous Byte-FIFO Bus Controller

This block sits in the FPGA fabric and drives the parallel side of an external USB bridge chip. The chip has an 8-bit shared data bus and five handshake lines, all active low. Two are flags from the chip: bytes waiting to be read, and room to write. Three are strobes from the FPGA: read, write, and a line that tells the chip to send its partly filled buffer to the host at once. On the fabric side the block has one byte stream for received data and one for data to transmit. Each stream uses a valid/ready handshake.

The chip's handshakes have no clock, so every timing limit is a number of nanoseconds. The block turns each limit into a whole number of cycles of its own clock, using a clock-period parameter. Each phase lasts ceil(ns / period) cycles, with a minimum of one. The two chip flags are resynchronised before the control logic uses them. When a flag is withdrawn, the block waits a recovery gap before it starts the next transfer in that direction. When a burst of transmit data ends, the block pulses the flush line once.

The data bus is split into an input, an output and an output enable. The pad can then be built at the chip boundary.

Top module: `fifobus_ctrl`

## Requirements
- R1: After reset the read, write and flush lines are high (inactive), the bus output enable is low, `rxValid` is low and `txReady` is low.
- R2: A read strobe starts only when two conditions hold: the synchronised receive flag is low and its recovery gap has expired, and the receive holding register is empty (`rxValid` low). While the flag is high, or while a received byte waits for `rxReady`, no read starts.
- R3: The read strobe stays low for 2 x ceil(15 ns / period) cycles. The byte on `busIn` is captured at the end of the first ceil(15 ns / period) cycles and is then offered on `rxData` with `rxValid` high.
- R4: The bus output enable is high only during the write phases. It is never high while the read strobe is low. After the read strobe rises, it stays low for at least 14 ns. The read and write strobes are never low at the same time.
- R5: When the receive flag rises (is deasserted), at least 49 ns pass before the next read strobe falls.
- R6: A transmit byte is accepted (`txValid` and `txReady` both high) only while the synchronised transmit flag is low and its recovery gap has expired. While the flag is high, `txReady` stays low and no write strobe occurs.
- R7: For each write, the accepted byte is driven on `busOut` with the output enable high for ceil(5 ns / period) cycles before the write strobe falls. The strobe then stays low for ceil(30 ns / period) cycles, and the byte stays unchanged while the strobe is low.
- R8: When the transmit flag rises, at least 49 ns pass before the next write strobe falls. The transmit flag is checked again before each byte.
- R9: After one or more writes, once `txValid` is low in the idle state, the flush line goes low once for ceil(250 ns / period) cycles. During that time no strobe is active and the bus is not driven.
- R10: When a read and a write first become possible in the same cycle, the read goes first and the write follows it.
- R11: Every phase length is computed from the clock-period parameter. With a 10 ns period the read strobe lasts 4 cycles. With a 20 ns period it lasts 2 cycles, because each 15 ns half rounds up to at least one cycle.
- R12: Each flag passes through a two-flop synchroniser. The read strobe falls on the third rising clock edge after the receive flag goes low, provided the idle block is otherwise free to read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busIn | input | DATA_W | Data bus as seen at the pad |
| busOut | output | DATA_W | Byte driven onto the bus during writes |
| busOe | output | 1 | Bus output enable, high while writing |
| rxAvailN | input | 1 | Chip flag, low when the host-to-chip FIFO has data |
| txRoomN | input | 1 | Chip flag, low when the chip-to-host FIFO has room |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| wakeN | output | 1 | Send-immediate/flush line, active low |
| rxData | output | DATA_W | Received byte |
| rxValid | output | 1 | Received byte is valid |
| rxReady | input | 1 | Fabric accepts the received byte |
| txData | input | DATA_W | Byte to transmit |
| txValid | input | 1 | Transmit byte is valid |
| txReady | output | 1 | Block accepts the transmit byte |

## Verification
A read and a write can become possible in the same cycle, and the block must then choose one. The bench sets up this clash deliberately. It first holds the transmit flag high so that no write can start while it loads a pending transmit byte. It then drops both chip flags at the same instant, so both pass the synchronisers on the same clock edge. The verdict comes from the order of strobe edges seen at the ports: the read strobe must fall first, and the write strobe must fall only after the read turnaround. A second case comes from the flush pulse, which could compete with a newly arriving transmit byte. The bench checks that a two-byte burst produces exactly one flush pulse, and that it comes only after the last byte.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int nsCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capRx;     // latch busIn into the receive register
    logic loadTx;    // latch txData into the transmit register
    logic driveBus;  // enable the bus output
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_HOLD,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END,
    ST_WAKE
  } state_t;

endpackage

// File: rtl/fbc_datapath.sv
module fbc_datapath
  import fbc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RECOV       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              rxAvailN,
  input  logic              txRoomN,
  input  ctl_t              ctl,
  output logic              rxOk,
  output logic              txOk,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData
);

  localparam int RW = $clog2(RECOV + 1);

  logic [1:0] rawN;
  logic [1:0] flagOk;
  assign rawN = {txRoomN, rxAvailN};

  // One synchroniser plus recovery timer for each chip flag.
  for (genvar g = 0; g < 2; g++) begin : gFlag
    logic [SYNC_STAGES-1:0] shReg;
    logic                   prevS;
    logic [RW-1:0]          recCnt;
    logic                   flagS;

    assign flagS = shReg[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shReg  <= '1;
        prevS  <= 1'b1;
        recCnt <= '0;
      end else begin
        shReg <= {shReg[SYNC_STAGES-2:0], rawN[g]};
        prevS <= flagS;
        if (flagS && !prevS)
          recCnt <= RW'(RECOV);
        else if (recCnt != '0)
          recCnt <= recCnt - 1'b1;
      end
    end

    assign flagOk[g] = !flagS && (recCnt == '0);
  end

  assign rxOk = flagOk[0];
  assign txOk = flagOk[1];

  logic [DATA_W-1:0] txReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      txReg   <= '0;
    end else begin
      if (ctl.capRx) begin
        rxData  <= busIn;
        rxValid <= 1'b1;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
      if (ctl.loadTx)
        txReg <= txData;
    end
  end

  assign busOut = txReg;
  assign busOe  = ctl.driveBus;

endmodule

// File: rtl/fbc_control.sv
module fbc_control
  import fbc_pkg::*;
#(
  parameter int RD_HALF  = 2,
  parameter int SETUP    = 1,
  parameter int WR_WIDTH = 3,
  parameter int TURN     = 2,
  parameter int WAKE_LEN = 25,
  parameter int GUARD    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxOk,
  input  logic txOk,
  input  logic rxValid,
  input  logic txValid,
  output logic txReady,
  output ctl_t ctl,
  output logic rdN,
  output logic wrN,
  output logic wakeN
);

  localparam int TURN_LEN = TURN + GUARD;
  localparam int MAX_LEN  = maxOf(maxOf(maxOf(RD_HALF, SETUP), maxOf(WR_WIDTH, TURN_LEN)),
                                  maxOf(WAKE_LEN, GUARD));
  localparam int CW       = $clog2(MAX_LEN + 1);

  state_t        state, nxt;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  logic          load;
  logic          flushPend;
  logic          done;

  assign done = (cnt == '0);

  always_comb begin
    nxt     = state;
    load    = 1'b0;
    len     = CW'(1);
    ctl     = '0;
    txReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rxOk && !rxValid) begin
          nxt = ST_RD_SETUP; load = 1'b1; len = CW'(RD_HALF);
        end else if (txOk && txValid) begin
          txReady    = 1'b1;
          ctl.loadTx = 1'b1;
          nxt = ST_WR_SETUP; load = 1'b1; len = CW'(SETUP);
        end else if (flushPend && !txValid) begin
          nxt = ST_WAKE; load = 1'b1; len = CW'(WAKE_LEN);
        end
      end
      ST_RD_SETUP: if (done) begin
        ctl.capRx = 1'b1;
        nxt = ST_RD_HOLD; load = 1'b1; len = CW'(RD_HALF);
      end
      ST_RD_HOLD: if (done) begin
        nxt = ST_RD_TURN; load = 1'b1; len = CW'(TURN_LEN);
      end
      ST_RD_TURN: if (done) nxt = ST_IDLE;
      ST_WR_SETUP: begin
        ctl.driveBus = 1'b1;
        if (done) begin nxt = ST_WR_PULSE; load = 1'b1; len = CW'(WR_WIDTH); end
      end
      ST_WR_PULSE: begin
        ctl.driveBus = 1'b1;
        if (done) begin nxt = ST_WR_END; load = 1'b1; len = CW'(GUARD); end
      end
      ST_WR_END: begin
        ctl.driveBus = 1'b1;
        if (done) nxt = ST_IDLE;
      end
      ST_WAKE: if (done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      flushPend <= 1'b0;
    end else begin
      state <= nxt;
      if (load)
        cnt <= len - 1'b1;
      else if (!done)
        cnt <= cnt - 1'b1;
      if (state == ST_WR_END && done)
        flushPend <= 1'b1;
      else if (nxt == ST_WAKE && state == ST_IDLE)
        flushPend <= 1'b0;
    end
  end

  assign rdN   = !(state == ST_RD_SETUP || state == ST_RD_HOLD);
  assign wrN   = !(state == ST_WR_PULSE);
  assign wakeN = !(state == ST_WAKE);

endmodule

// File: rtl/fifobus_ctrl.sv
module fifobus_ctrl
  import fbc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              rxAvailN,
  input  logic              txRoomN,
  output logic              rdN,
  output logic              wrN,
  output logic              wakeN,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);

  localparam int RD_HALF  = nsCycles(15, CLK_NS);
  localparam int SETUP    = nsCycles(5, CLK_NS);
  localparam int WR_WIDTH = nsCycles(30, CLK_NS);
  localparam int TURN     = nsCycles(14, CLK_NS);
  localparam int RECOV    = nsCycles(49, CLK_NS);
  localparam int WAKE_LEN = nsCycles(250, CLK_NS);

  ctl_t ctl;
  logic rxOk;
  logic txOk;

  fbc_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .RECOV(RECOV)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .rxAvailN(rxAvailN), .txRoomN(txRoomN), .ctl(ctl), .rxOk(rxOk), .txOk(txOk),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .txData(txData)
  );

  fbc_control #(
    .RD_HALF(RD_HALF), .SETUP(SETUP), .WR_WIDTH(WR_WIDTH), .TURN(TURN),
    .WAKE_LEN(WAKE_LEN), .GUARD(SYNC_STAGES)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .rxOk(rxOk), .txOk(txOk), .rxValid(rxValid),
    .txValid(txValid), .txReady(txReady), .ctl(ctl), .rdN(rdN), .wrN(wrN),
    .wakeN(wakeN)
  );

endmodule

// File: rtl/fbc_checker.sv
module fbc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdN,
  input logic              wrN,
  input logic              wakeN,
  input logic              busOe,
  input logic [DATA_W-1:0] busOut,
  input logic              rxValid,
  input logic              txValid,
  input logic              txReady,
  input logic              rxOk,
  input logic              txOk
);

  // R4: no bus drive while reading
  a_r4_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rdN |-> !busOe);

  // R4: strobes are mutually exclusive
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !rdN |-> wrN);

  // R2: read begins only with flag ready and slot empty
  a_r2_read_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdN) |-> ($past(rxOk) && !$past(rxValid)));

  // R6: transmit acceptance only with room
  a_r6_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |-> txOk);

  // R7: byte held and driven through the strobe
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrN |-> (busOe && $stable(busOut)));

  // R9: flush pulse is quiet on the bus
  a_r9_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wakeN |-> (wrN && rdN && !busOe));

  // R10: write never chosen over a possible read
  a_r10_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |-> (!rxOk || rxValid));

endmodule

bind fifobus_ctrl fbc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdN(rdN), .wrN(wrN), .wakeN(wakeN), .busOe(busOe),
  .busOut(busOut), .rxValid(rxValid), .txValid(txValid), .txReady(txReady),
  .rxOk(rxOk), .txOk(txOk)
);

// File: tb/fifobus_ctrl_tb.sv
`timescale 1ns/1ps
module fifobus_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] busIn, busOut, rxData, txData, rdByte;
  logic       busOe, rxAvailN, txRoomN, rdN, wrN, wakeN;
  logic       rxValid, rxReady, txValid, txReady;
  logic       mon = 1'b0;
  logic       done = 1'b0;
  int         total = 0, bad = 0;

  always #2.5 clk = ~clk;

  fifobus_ctrl #(.DATA_W(8), .CLK_NS(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .rxAvailN(rxAvailN), .txRoomN(txRoomN), .rdN(rdN), .wrN(wrN), .wakeN(wakeN),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .txData(txData),
    .txValid(txValid), .txReady(txReady)
  );

  // Two more instances: same inputs pattern, other period parameters (R11).
  logic [7:0] p10Out, p10Rx, p20Out, p20Rx;
  logic p10Oe, p10Rd, p10Wr, p10Wk, p10Rv, p10Tr;
  logic p20Oe, p20Rd, p20Wr, p20Wk, p20Rv, p20Tr;

  fifobus_ctrl #(.DATA_W(8), .CLK_NS(10)) u_p10 (
    .clk(clk), .rst_n(rst_n), .busIn(8'h5A), .busOut(p10Out), .busOe(p10Oe),
    .rxAvailN(1'b0), .txRoomN(1'b1), .rdN(p10Rd), .wrN(p10Wr), .wakeN(p10Wk),
    .rxData(p10Rx), .rxValid(p10Rv), .rxReady(1'b1), .txData(8'h00),
    .txValid(1'b0), .txReady(p10Tr)
  );

  fifobus_ctrl #(.DATA_W(8), .CLK_NS(20)) u_p20 (
    .clk(clk), .rst_n(rst_n), .busIn(8'h5A), .busOut(p20Out), .busOe(p20Oe),
    .rxAvailN(1'b0), .txRoomN(1'b1), .rdN(p20Rd), .wrN(p20Wr), .wakeN(p20Wk),
    .rxData(p20Rx), .rxValid(p20Rv), .rxReady(1'b1), .txData(8'h00),
    .txValid(1'b0), .txReady(p20Tr)
  );

  // ---------------- monitors ----------------
  realtime rdFallT = 0, rdRiseT = -100, rdW = 0, wrFallT = 0, wrW = 0;
  realtime wkFallT = 0, wkW = 0, oeRiseT = 0, setupT = 0;
  realtime rxRiseT = -1000, txRiseT = -1000, rxGap = 1000, txGap = 1000;
  realtime p10F = 0, p10W = 0, p20F = 0, p20W = 0;
  int rdFalls = 0, wrFalls = 0, wkFalls = 0, txAcc = 0, rxCnt = 0;
  int oeInRead = 0, oeTurnViol = 0, wrWhileFull = 0;
  logic [7:0] rxLog = 8'h00, wrByte = 8'h00;
  logic       wrOe = 1'b0;

  always @(negedge rdN) if (mon) begin
    rdFallT = $realtime; rdFalls++; rxGap = $realtime - rxRiseT;
  end
  always @(posedge rdN) if (mon) begin rdW = $realtime - rdFallT; rdRiseT = $realtime; end
  always @(negedge wrN) if (mon) begin
    wrFallT = $realtime; wrFalls++; setupT = $realtime - oeRiseT;
    wrByte = busOut; wrOe = busOe; txGap = $realtime - txRiseT;
    if (txRoomN) wrWhileFull++;
  end
  always @(posedge wrN) if (mon) wrW = $realtime - wrFallT;
  always @(negedge wakeN) if (mon) begin wkFallT = $realtime; wkFalls++; end
  always @(posedge wakeN) if (mon) wkW = $realtime - wkFallT;
  always @(posedge busOe) if (mon) begin
    oeRiseT = $realtime;
    if ($realtime - rdRiseT < 14.0) oeTurnViol++;
  end
  always @(posedge rxAvailN) rxRiseT = $realtime;
  always @(posedge txRoomN) txRiseT = $realtime;
  always @(negedge clk) if (mon) begin
    if (!rdN && busOe) oeInRead++;
    if (rxValid && rxReady) begin rxLog = rxData; rxCnt++; end
    if (txValid && txReady) txAcc++;
  end
  always @(negedge p10Rd) p10F = $realtime;
  always @(posedge p10Rd) p10W = $realtime - p10F;
  always @(negedge p20Rd) p20F = $realtime;
  always @(posedge p20Rd) p20W = $realtime - p20F;

  // Chip read-side model: data valid 12 ns after strobe falls, released after rise.
  always begin
    @(negedge rdN);
    if (mon) begin
      busIn = 8'hEE;
      #12 busIn = rdByte;
      @(posedge rdN);
      #6 busIn = 8'h00;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    int a0;
    @(negedge clk);
    a0 = txAcc;
    txData  = b;
    txValid = 1'b1;
    wait (txAcc > a0);
    @(posedge clk);
    #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(rdN == 1'b1,    "R1", "rdN idle", rdN, 1);
    chk(wrN == 1'b1,    "R1", "wrN idle", wrN, 1);
    chk(wakeN == 1'b1,  "R1", "wakeN idle", wakeN, 1);
    chk(busOe == 1'b0,  "R1", "busOe idle", busOe, 0);
    chk(rxValid == 1'b0,"R1", "rxValid idle", rxValid, 0);
    chk(txReady == 1'b0,"R1", "txReady idle", txReady, 0);
  endtask

  task automatic t_sync_latency();
    @(negedge clk);
    rdByte = 8'h3C; rxReady = 1'b1; rxAvailN = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(rdN == 1'b1, "R12", "rdN after two edges", rdN, 1);
    @(posedge clk); @(negedge clk);
    chk(rdN == 1'b0, "R12", "rdN after third edge", rdN, 0);
    @(posedge rdN);
    #4 rxAvailN = 1'b1;
    cycles(30);
    chk(near(rdW, 30.0), "R3", "read strobe ns", rdW, 30.0);
    chk(rxLog == 8'h3C, "R3", "captured byte", rxLog, 8'h3C);
  endtask

  task automatic t_read_recovery();
    @(negedge clk);
    rdByte = 8'h81; rxAvailN = 1'b0;
    @(posedge rdN);
    #4 rxAvailN = 1'b1;
    #10 begin rdByte = 8'h82; rxAvailN = 1'b0; end
    @(negedge rdN);
    chk(rxGap >= 49.0, "R5", "flag rise to next read ns", rxGap, 49.0);
    @(posedge rdN);
    #4 rxAvailN = 1'b1;
    cycles(30);
    chk(rxLog == 8'h82, "R3", "second byte", rxLog, 8'h82);
    chk(oeInRead == 0, "R4", "oe during read", oeInRead, 0);
  endtask

  task automatic t_backpressure();
    int n0;
    @(negedge clk);
    rxReady = 1'b0; rdByte = 8'h44; rxAvailN = 1'b0;
    @(posedge rdN);
    #4 rxAvailN = 1'b1;
    #10 begin rdByte = 8'h45; rxAvailN = 1'b0; end
    n0 = rdFalls;
    cycles(40);
    chk(rdFalls == n0, "R2", "reads while slot full", rdFalls - n0, 0);
    chk(rxValid == 1'b1 && rxData == 8'h44, "R2", "held byte", rxData, 8'h44);
    @(negedge clk);
    rxReady = 1'b1;
    wait (rdFalls > n0);
    @(posedge rdN);
    #4 rxAvailN = 1'b1;
    cycles(30);
    chk(rxLog == 8'h45, "R2", "byte after release", rxLog, 8'h45);
    n0 = rdFalls;
    cycles(40);
    chk(rdFalls == n0, "R2", "reads with flag high", rdFalls - n0, 0);
  endtask

  task automatic t_write_single();
    int k0;
    k0 = wkFalls;
    pushByte(8'hA5);
    txValid = 1'b0;
    cycles(80);
    chk(wrByte == 8'hA5, "R7", "byte at strobe", wrByte, 8'hA5);
    chk(wrOe == 1'b1, "R7", "oe at strobe", wrOe, 1);
    chk(near(setupT, 5.0), "R7", "setup ns", setupT, 5.0);
    chk(near(wrW, 30.0), "R7", "write strobe ns", wrW, 30.0);
    chk(wkFalls == k0 + 1, "R9", "flush pulses", wkFalls - k0, 1);
    chk(near(wkW, 250.0), "R9", "flush width ns", wkW, 250.0);
  endtask

  task automatic t_tx_full();
    int w0, rdyHits;
    @(negedge clk);
    txRoomN = 1'b1;
    cycles(20);
    w0 = wrFalls; rdyHits = 0;
    @(negedge clk);
    txData = 8'h5E; txValid = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (txReady) rdyHits++;
    end
    chk(rdyHits == 0, "R6", "txReady while full", rdyHits, 0);
    chk(wrFalls == w0, "R6", "writes while full", wrFalls - w0, 0);
    txRoomN = 1'b0;
    wait (txAcc > 0 && wrFalls > w0);
    @(negedge clk);
    txValid = 1'b0;
    cycles(80);
    chk(wrByte == 8'h5E, "R6", "byte after room", wrByte, 8'h5E);
    chk(wrFalls == w0 + 1, "R6", "single write", wrFalls - w0, 1);
  endtask

  task automatic t_tx_recovery();
    int k0, w0;
    k0 = wkFalls; w0 = wrFalls;
    fork
      begin
        @(negedge wrN);
        #8 txRoomN = 1'b1;
        #20 txRoomN = 1'b0;
      end
    join_none
    pushByte(8'h11);
    pushByte(8'h22);
    txValid = 1'b0;
    wait (wrFalls == w0 + 2);
    chk(txGap >= 49.0, "R8", "room rise to next write ns", txGap, 49.0);
    chk(wrByte == 8'h22, "R8", "second byte", wrByte, 8'h22);
    cycles(80);
    chk(wrWhileFull == 0, "R8", "writes with flag high", wrWhileFull, 0);
    chk(wkFalls == k0 + 1, "R9", "one flush per burst", wkFalls - k0, 1);
  endtask

  task automatic t_priority();
    int r0, w0, a0;
    @(negedge clk);
    txRoomN = 1'b1;
    cycles(25);
    @(negedge clk);
    r0 = rdFalls; w0 = wrFalls; a0 = txAcc;
    txData = 8'h77; txValid = 1'b1; rdByte = 8'h99;
    @(negedge clk);
    rxAvailN = 1'b0; txRoomN = 1'b0;
    wait (rdFalls > r0 || wrFalls > w0);
    chk(rdFalls > r0 && wrFalls == w0, "R10", "read strobe first", wrFalls - w0, 0);
    @(posedge rdN);
    #4 rxAvailN = 1'b1;
    wait (txAcc > a0);
    @(posedge clk);
    #1 txValid = 1'b0;
    wait (wrFalls > w0);
    chk(wrFallT > rdFallT, "R10", "write after read", wrFallT, rdFallT);
    cycles(80);
    chk(wrByte == 8'h77, "R10", "written byte", wrByte, 8'h77);
    chk(rxLog == 8'h99, "R10", "read byte", rxLog, 8'h99);
    chk(oeTurnViol == 0, "R4", "oe inside turnaround", oeTurnViol, 0);
  endtask

  task automatic t_params();
    chk(near(p10W, 20.0), "R11", "10ns period strobe (4 cycles)", p10W, 20.0);
    chk(near(p20W, 10.0), "R11", "20ns period strobe (2 cycles)", p20W, 10.0);
  endtask

  // ---------------- sequence ----------------
  initial begin
    rst_n = 1'b0; rxAvailN = 1'b1; txRoomN = 1'b0; txValid = 1'b0;
    rxReady = 1'b1; busIn = 8'h00; txData = 8'h00; rdByte = 8'h00;
    cycles(4);
    @(negedge clk);
    rst_n = 1'b1;
    mon = 1'b1;
    t_reset();
    cycles(5);
    t_sync_latency();
    t_read_recovery();
    t_backpressure();
    t_write_single();
    t_tx_full();
    t_tx_recovery();
    t_priority();
    t_params();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL all watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule